// File: doc/BRIEF.md
# Serial Port Bit-Clock Divider

This block makes the bit clock for a synchronous serial port. It runs entirely in the system-clock domain. It counts input ticks, which come from one of two sources. The first is an internal tick at half the system clock rate. The second is the rising edge of an external clock pin after a synchronizer. One output period spans a programmed 8-bit divide value plus one input ticks. The high and low phases follow a fixed split rule. A divide value of zero bypasses the counter, so the output runs at the input rate.

Four outputs come from this clock: the raw bit clock, a copy whose polarity can be inverted, and one-cycle strobes that mark the rising and falling edges of that copy. Downstream logic uses the strobes as clock enables. A new divide value is taken only when the output rises, so reprogramming never produces a short phase.

Top module: `sp_bitclk_gen`

## Requirements
- R1: In divide mode (divide value N from 1 to 255), one output period lasts N+1 input ticks.
- R2: When N is even and nonzero, the high phase lasts N/2+1 ticks and the low phase lasts N/2 ticks.
- R3: When N is odd, the high and low phases each last (N+1)/2 ticks.
- R4: When N is 0 the counter is bypassed. With the internal source the output is high for one system clock and low for one. With the external source the output follows the synchronized external level.
- R5: `src_int`=1 selects an internal tick every second system clock, and `src_int`=0 selects the synchronized rising edge of `ext_clk`. A phase of k ticks therefore lasts 2k system clocks or k external periods.
- R6: The bit clock never rises in two consecutive system clocks, so it is never faster than half the system clock.
- R7: A change to `div_val` has no effect on the output until the next rising edge of the output. The phases in progress keep the old value.
- R8: While `rst` is high at a clock edge, `bclk` is 0 and both strobes are 0.
- R9: `bclk_pol` equals `bclk` when `pol_inv`=0 and equals its inverse when `pol_inv`=1. The strobes refer to `bclk_pol`.
- R10: `rise_stb` is high for exactly one system clock when `bclk_pol` goes from 0 to 1. `fall_stb` is high for exactly one system clock when it goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_int | input | 1 | 1: internal half-rate tick; 0: external clock |
| ext_clk | input | 1 | External clock pin, asynchronous |
| div_val | input | 8 | Divide value N |
| pol_inv | input | 1 | Invert the polarity of `bclk_pol` |
| bclk | output | 1 | Bit clock, true polarity |
| bclk_pol | output | 1 | Bit clock after the polarity control |
| rise_stb | output | 1 | One-cycle strobe on a rising edge of `bclk_pol` |
| fall_stb | output | 1 | One-cycle strobe on a falling edge of `bclk_pol` |

## Verification
The assertions check these properties on every cycle:
- the output is low and the strobes are quiet during reset;
- no two rising edges of the bit clock come in adjacent cycles;
- the latched divide value changes only at an output rising edge;
- each strobe lasts one cycle and sits on a real transition of the polarity-adjusted clock.

The phase lengths for even, odd and zero divide values can only be shown by the bench scenarios, which measure whole periods. So can the scaling by source, the polarity swap of the high and low lengths, and the old value holding after a mid-period reprogramming.

// File: rtl/sp_bitclk_pkg.sv
package sp_bitclk_pkg;

  // Ticks spent high for divide value d (d > 0); 0 means bypass.
  function automatic int unsigned hi_ticks(input int unsigned d);
    if (d == 0) return 0;
    if (d[0]) return (d + 1) / 2;
    return d / 2 + 1;
  endfunction

  // Ticks spent low for divide value d (d > 0).
  function automatic int unsigned lo_ticks(input int unsigned d);
    if (d == 0) return 0;
    if (d[0]) return (d + 1) / 2;
    return d / 2;
  endfunction

endpackage

// File: rtl/sp_bitclk_tick_src.sv
module sp_bitclk_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_int,
  input  logic ext_clk,
  output logic tick,
  output logic ext_lvl
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   half_ph;
  logic                   ext_tick;

  // synchronizer chain on the external pin
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign ext_lvl = sync_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b0;
      half_ph  <= 1'b0;
    end else begin
      ext_prev <= ext_lvl;
      half_ph  <= ~half_ph;
    end
  end

  assign ext_tick = ext_lvl & ~ext_prev;
  assign tick     = src_int ? half_ph : ext_tick;

endmodule

// File: rtl/sp_bitclk_div_core.sv
module sp_bitclk_div_core
  import sp_bitclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             src_int,
  input  logic             ext_lvl,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk,
  output logic [DIV_W-1:0] div_act,
  output logic             core_rise
);
  localparam int CNT_W = DIV_W;
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1);

  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic [DIV_W-1:0] nxt_div;
  logic             nxt_bclk;
  logic             bypass;

  assign bypass = (div_act == '0);

  always_comb begin
    nxt_bclk = bclk;
    nxt_cnt  = cnt;
    nxt_div  = div_act;
    if (bypass) begin
      nxt_bclk = src_int ? ~bclk : ext_lvl;
    end else if (tick) begin
      if (cnt <= CNT_W'(1)) begin
        if (bclk) begin
          nxt_bclk = 1'b0;
          nxt_cnt  = CNT_W'(lo_ticks(int'(div_act)));
        end else begin
          nxt_bclk = 1'b1;
        end
      end else begin
        nxt_cnt = cnt - CNT_W'(1);
      end
    end
    core_rise = nxt_bclk & ~bclk;
    if (core_rise) begin
      nxt_div = div_val;
      nxt_cnt = CNT_W'(hi_ticks(int'(div_val)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk    <= 1'b0;
      cnt     <= '0;
      div_act <= DIV_RST;
    end else begin
      bclk    <= nxt_bclk;
      cnt     <= nxt_cnt;
      div_act <= nxt_div;
    end
  end

endmodule

// File: rtl/sp_bitclk_edge_out.sv
module sp_bitclk_edge_out (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic pol_inv,
  output logic bclk_pol,
  output logic rise_stb,
  output logic fall_stb
);
  logic pol_q;

  assign bclk_pol = bclk ^ pol_inv;

  always_ff @(posedge clk) begin
    pol_q <= bclk_pol;
  end

  assign rise_stb = ~rst & bclk_pol & ~pol_q;
  assign fall_stb = ~rst & ~bclk_pol & pol_q;

endmodule

// File: rtl/sp_bitclk_gen.sv
module sp_bitclk_gen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_int,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div_val,
  input  logic             pol_inv,
  output logic             bclk,
  output logic             bclk_pol,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic             tick;
  logic             ext_lvl;
  logic             core_rise;
  logic [DIV_W-1:0] div_act;

  sp_bitclk_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst     (rst),
    .src_int (src_int),
    .ext_clk (ext_clk),
    .tick    (tick),
    .ext_lvl (ext_lvl)
  );

  sp_bitclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .src_int   (src_int),
    .ext_lvl   (ext_lvl),
    .div_val   (div_val),
    .bclk      (bclk),
    .div_act   (div_act),
    .core_rise (core_rise)
  );

  sp_bitclk_edge_out u_out (
    .clk      (clk),
    .rst      (rst),
    .bclk     (bclk),
    .pol_inv  (pol_inv),
    .bclk_pol (bclk_pol),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

endmodule

// File: rtl/sp_bitclk_chk.sv
module sp_bitclk_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bclk,
  input logic             bclk_pol,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             core_rise,
  input logic [DIV_W-1:0] div_act
);

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !bclk) else $error("bclk high after reset edge"); // R8
  AST_RST_NO_STB: assert property (@(posedge clk) rst |-> (!rise_stb && !fall_stb)) else $error("strobe in reset"); // R8
  AST_HALF_RATE_MAX: assert property (@(posedge clk) disable iff (rst) core_rise |=> !core_rise) else $error("bit clock too fast"); // R6
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst) !core_rise |=> $stable(div_act)) else $error("divide changed off a rise"); // R7
  AST_RISE_ONE: assert property (@(posedge clk) disable iff (rst) rise_stb |=> !rise_stb) else $error("rise strobe too long"); // R10
  AST_FALL_ONE: assert property (@(posedge clk) disable iff (rst) fall_stb |=> !fall_stb) else $error("fall strobe too long"); // R10
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst) !(rise_stb && fall_stb)) else $error("both strobes"); // R10
  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst) rise_stb |=> (fall_stb || bclk_pol)) else $error("rise strobe level"); // R9

endmodule

bind sp_bitclk_gen sp_bitclk_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bclk      (bclk),
  .bclk_pol  (bclk_pol),
  .rise_stb  (rise_stb),
  .fall_stb  (fall_stb),
  .core_rise (core_rise),
  .div_act   (div_act)
);

// File: tb/sp_bitclk_gen_test.sv
`timescale 1ns/1ps
module sp_bitclk_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_int = 1'b1;
  logic       ext_clk = 1'b0;
  logic [7:0] div_val = 8'd4;
  logic       pol_inv = 1'b0;
  logic       bclk, bclk_pol, rise_stb, fall_stb;
  int         n_chk = 0;
  int         n_bad = 0;
  int         ext_half = 3;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sp_bitclk_gen uut (
    .clk(clk), .rst(rst), .src_int(src_int), .ext_clk(ext_clk),
    .div_val(div_val), .pol_inv(pol_inv), .bclk(bclk),
    .bclk_pol(bclk_pol), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // external clock: ext_half system clocks per level
  initial begin
    forever begin
      repeat (ext_half) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  // expected phase lengths in ticks: the high phase always takes the upper half
  function automatic int want_hi(int d);
    return (d >> 1) + 1;
  endfunction
  function automatic int want_lo(int d);
    return d + 1 - want_hi(d);
  endfunction

  task automatic check(string tag, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb);
  endtask

  // from a rise strobe, length of high phase then low phase, in system clocks
  task automatic span(output int hi, output int lo);
    hi = 0;
    do begin @(negedge clk); hi++; end while (!fall_stb);
    lo = 0;
    do begin @(negedge clk); lo++; end while (!rise_stb);
  endtask

  task automatic measure(string tag, int exp_hi, int exp_lo);
    int hi, lo;
    wait_rise(); wait_rise(); wait_rise();
    span(hi, lo);
    check(tag, hi, exp_hi, "high length");
    check(tag, lo, exp_lo, "low length");
  endtask

  task automatic run_div(int d, bit internal);
    int unit;
    string tag;
    div_val = 8'(d);
    src_int = internal;
    unit = internal ? 2 : 2 * ext_half;
    if (d == 0)            tag = "R4";
    else if (d % 2 == 0)   tag = "R2";
    else                   tag = "R3";
    if (d == 0) measure(tag, internal ? 1 : ext_half, internal ? 1 : ext_half);
    else        measure(tag, unit * want_hi(d), unit * want_lo(d));
  endtask

  initial begin
    int hi, lo;
    int d;
    void'($urandom(32'd1234));

    // R8: reset holds the output low and the strobes quiet
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8", {31'd0, bclk}, 0, "bclk in reset");
      check("R8", {30'd0, rise_stb, fall_stb}, 0, "strobes in reset");
    end
    @(negedge clk); rst = 1'b0;

    // R1: whole period, internal source
    div_val = 8'd6;
    wait_rise(); wait_rise();
    span(hi, lo);
    check("R1", hi + lo, 2 * 7, "period N=6");

    // R2, R3: directed even and odd values, internal
    run_div(2, 1'b1);
    run_div(1, 1'b1);
    run_div(3, 1'b1);
    run_div(255, 1'b1);
    run_div(254, 1'b1);

    // R4 and R6: bypass with internal source is one clock high, one low
    run_div(0, 1'b1);
    wait_rise(); span(hi, lo);
    check("R6", hi + lo, 2, "fastest period");

    // R5: external source
    run_div(5, 1'b0);
    run_div(4, 1'b0);
    run_div(0, 1'b0);
    div_val = 8'd6;
    wait_rise(); wait_rise(); wait_rise();
    span(hi, lo);
    check("R5", hi + lo, 7 * 2 * ext_half, "external period N=6");

    // random values, both sources
    for (int i = 0; i < 14; i++) begin
      d = int'($urandom_range(40, 0));
      run_div(d, ($urandom_range(1, 0) == 1));
    end

    // R7: reprogram just after a rise; the current period keeps the old value
    src_int = 1'b1;
    div_val = 8'd9;
    wait_rise(); wait_rise(); wait_rise();
    div_val = 8'd3;
    span(hi, lo);
    check("R7", hi, 10, "high after change");
    check("R7", lo, 10, "low after change");
    span(hi, lo);
    check("R7", hi, 4, "new high");
    check("R7", lo, 4, "new low");

    // R9: inverted polarity swaps the phase lengths seen on bclk_pol
    div_val = 8'd4;
    pol_inv = 1'b1;
    measure("R9", 2 * want_lo(4), 2 * want_hi(4));
    check("R9", {31'd0, bclk_pol}, {31'd0, ~bclk}, "inverted level");
    pol_inv = 1'b0;
    @(negedge clk);
    check("R9", {31'd0, bclk_pol}, {31'd0, bclk}, "true level");

    // R10: a rise strobe lasts one clock
    wait_rise();
    @(negedge clk);
    check("R10", {31'd0, rise_stb}, 0, "rise strobe width");

    // R8: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R8", {31'd0, bclk}, 0, "bclk after mid reset");
    check("R8", {30'd0, rise_stb, fall_stb}, 0, "strobes mid reset");
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule